// File: doc/BRIEF.md
# UART register and interrupt controller

This block is the software-facing register file of a serial port. It sits between a 32-bit register bus and a byte-level serial core. The bus reads and writes eleven word registers: three control words, a baud divisor, a guard/prescale word, a timeout word, a write-only request word, a read-only status word, a write-one-to-clear word, and the receive and transmit data words. The divisor, guard and timeout words and most control fields are only stored for the serial core. They do not change the behaviour of this block.

Received characters arrive on a valid/ready port. A character is taken in any cycle where `rx_valid` is high, and `rx_ready` only tells the core whether the receive slot is free. Characters to send leave on a valid/ready port. The block keeps four flags of its own: receive-full, overrun, transmit-empty and transmit-complete. It also latches line events that the serial core reports. It drives one level interrupt, which is the OR of fixed flag and enable pairs.

Top module: `uart_csr_ctrl`

## Requirements
- R1: After reset every register reads zero, except the status word at 0x1C, which reads 0x020000C0. In that value transmit-empty (bit 7) and transmit-complete (bit 6) are set.
- R2: Word offsets are:
  - control A at 0x00, control B at 0x04 and control C at 0x08, all read back in full;
  - divisor at 0x0C, which reads back only its low 16 bits;
  - guard at 0x10 and timeout at 0x14, read back in full;
  - request at 0x18, status at 0x1C, clear at 0x20, receive data at 0x24 and transmit data at 0x28.

  Request and clear always read zero. An unaligned address or an address outside the map reads zero, and a write to it changes nothing.
- R3: An arriving character is dropped unless control A bit 0 (enable) and bit 2 (receiver on) are both set. A dropped character leaves the receive data and the status untouched.
- R4: An accepted character goes into the receive data word and sets receive-full (status bit 5). `rx_ready` is high exactly while receive-full is clear.
- R5: If a character arrives while receive-full is set and control C bit 12 (overrun detect off) is clear, overrun (status bit 3) is set and the stored character is kept. If bit 12 is set, the new character overwrites the old one.
- R6: Reading 0x24 returns the stored character zero-extended and clears receive-full. Writing the request word with bit 3 set also clears receive-full. If a character is stored in the same cycle, receive-full stays set.
- R7: Writing 0x28 stores the character and clears transmit-empty. `tx_valid` is high while transmit-empty is clear and control A bit 3 (transmitter on) is set, and `tx_data` then carries the stored character.
- R8: In a cycle where `tx_valid` and `tx_ready` are both high, transmit-empty and transmit-complete are set. If 0x28 is written in that same cycle, transmit-empty stays clear for the new character.
- R9: Writing the clear word clears each status bit whose position holds a 1. A flag that is set in the same cycle stays set. Writes to the status word and to the receive data word are ignored.
- R10: A 1 on `core_evt` sets the status bit at the same position. Only positions 0, 1, 2, 4, 8, 9, 11, 12, 17 and 20 can be set this way.
- R11: `irq` is high when any of the following pairs is active:
  - status 7 with control A 7
  - status 6 with A 6
  - status 5 with A 5
  - status 4 with A 4
  - status 0 with A 8
  - status 17 with A 14
  - status 11 with A 26
  - status 12 with A 27
  - status 9 with control C 10
  - status 8 with control B 6
  - status 20 with C 22
  - status 1 with C 0
  - status 3 with A 5 or C 0
- R12: With the default combinational interrupt variant, `irq` follows the flag and enable registers in the same cycle they change. No extra register stage lies on that path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects at the clock edge) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle bus_rd is high |
| rx_valid | input | 1 | Character arriving from the serial core |
| rx_data | input | DATA_W | Arriving character |
| rx_ready | output | 1 | Receive slot free |
| tx_valid | output | 1 | Character offered to the serial core |
| tx_data | output | DATA_W | Offered character |
| tx_ready | input | 1 | Serial core accepts the offered character |
| core_evt | input | 32 | Line-event set pulses from the serial core |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with `DATA_W` = 9, so every bit of the 9-bit receive data field is exercised, including bit 8 at the top. It uses `ADDR_W` = 10, which covers the full 1 KiB window, so addresses far past the map are reached as well. It uses the combinational interrupt variant, so the same-cycle response of `irq` is compared in every cycle. These values also bring within reach the collisions the requirements call out:
- a clear and a set of the same flag in one cycle;
- a transmit-data write in the cycle the previous character is taken;
- a character arriving while the slot is full, with overrun detection both on and off.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
   localparam int unsigned REG_W       = 32;
   localparam int unsigned RDR_FIELD_W = 9;
   localparam int unsigned DIV_W       = 16;
   localparam int unsigned MIN_ADDR_W  = 6;
   localparam int unsigned NUM_WORDS   = 11;

   // word indices (byte offset / 4)
   localparam int unsigned W_CTLA  = 0;
   localparam int unsigned W_CTLB  = 1;
   localparam int unsigned W_CTLC  = 2;
   localparam int unsigned W_DIV   = 3;
   localparam int unsigned W_GUARD = 4;
   localparam int unsigned W_TMO   = 5;
   localparam int unsigned W_REQ   = 6;
   localparam int unsigned W_STAT  = 7;
   localparam int unsigned W_CLR   = 8;
   localparam int unsigned W_RXD   = 9;
   localparam int unsigned W_TXD   = 10;

   // status positions owned by the data paths
   localparam int unsigned ST_OVR  = 3;
   localparam int unsigned ST_FULL = 5;
   localparam int unsigned ST_DONE = 6;
   localparam int unsigned ST_EMPTY = 7;

   // control positions decoded by this block
   localparam int unsigned CA_ON     = 0;
   localparam int unsigned CA_RX_ON  = 2;
   localparam int unsigned CA_TX_ON  = 3;
   localparam int unsigned CC_OVR_OFF = 12;
   localparam int unsigned RQ_FLUSH  = 3;

   localparam logic [REG_W-1:0] ST_RESET   = 32'h0200_00C0;
   localparam logic [REG_W-1:0] OWNED_MASK = 32'h0000_00E8;
   localparam logic [REG_W-1:0] EVT_MASK   = 32'h0012_1B17;

   // interrupt pairs: flag position, enable position in {ctlC, ctlB, ctlA}
   localparam int unsigned NUM_PAIRS = 14;
   localparam int unsigned PAIR_FLAG [NUM_PAIRS] =
      '{7, 6, 5, 4, 0, 17, 11, 12, 9, 8, 20, 1, 3, 3};
   localparam int unsigned PAIR_EN [NUM_PAIRS] =
      '{7, 6, 5, 4, 8, 14, 26, 27, 74, 38, 86, 64, 5, 64};
endpackage

// File: rtl/uart_csr_rx.sv
module uart_csr_rx #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              accept_en,
   input  logic              ovr_detect,
   input  logic              clr_full,
   input  logic              clr_ovr,
   output logic              full,
   output logic              ovr,
   output logic              rx_ready,
   output logic [DATA_W-1:0] data_q
);
   logic arrive, store, lost;

   assign arrive   = rx_valid && accept_en;
   assign store    = arrive && (!full || !ovr_detect);
   assign lost     = arrive && full && ovr_detect;
   assign rx_ready = !full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full   <= 1'b0;
         ovr    <= 1'b0;
         data_q <= '0;
      end else begin
         full <= store ? 1'b1 : (full && !clr_full);
         ovr  <= lost  ? 1'b1 : (ovr && !clr_ovr);
         if (store) data_q <= rx_data;
      end
   end
endmodule

// File: rtl/uart_csr_tx.sv
module uart_csr_tx #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              tx_on,
   input  logic              tx_ready,
   input  logic              clr_empty,
   input  logic              clr_done,
   output logic              empty,
   output logic              done,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data
);
   logic taken;

   assign tx_valid = !empty && tx_on;
   assign taken    = tx_valid && tx_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         empty   <= 1'b1;
         done    <= 1'b1;
         tx_data <= '0;
      end else begin
         if (load)       empty <= 1'b0;
         else if (taken) empty <= 1'b1;
         else            empty <= empty && !clr_empty;
         done <= taken ? 1'b1 : (done && !clr_done);
         if (load) tx_data <= load_data;
      end
   end
endmodule

// File: rtl/uart_csr_irq.sv
module uart_csr_irq
   import uart_csr_pkg::*;
#(
   parameter int unsigned IRQ_REG = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [REG_W-1:0]   status,
   input  logic [3*REG_W-1:0] enables,
   output logic               irq
);
   logic [NUM_PAIRS-1:0] hit;
   logic                 any_hit;

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      assign hit[p] = status[PAIR_FLAG[p]] && enables[PAIR_EN[p]];
   end

   assign any_hit = |hit;

   if (IRQ_REG == 0) begin : g_comb
      assign irq = any_hit;
   end else begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= any_hit;
      end
   end
endmodule

// File: rtl/uart_csr_ctrl.sv
module uart_csr_ctrl
   import uart_csr_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned ADDR_W  = 10,
   parameter int unsigned IRQ_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              tx_ready,
   input  logic [REG_W-1:0]  core_evt,
   output logic              irq
);
   localparam int unsigned WORD_W = ADDR_W - 2;

   if (DATA_W < 5 || DATA_W > RDR_FIELD_W) begin : g_bad_data_w
      $error("uart_csr_ctrl: DATA_W must lie in 5..9");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr_w
      $error("uart_csr_ctrl: ADDR_W too small for the register map");
   end
   if (IRQ_REG > 1) begin : g_bad_irq_reg
      $error("uart_csr_ctrl: IRQ_REG must be 0 or 1");
   end

   logic                 aligned;
   logic [WORD_W-1:0]    word;
   logic [NUM_WORDS-1:0] sel, wr_sel, rd_sel;

   assign aligned = (bus_addr[1:0] == 2'b00);
   assign word    = bus_addr[ADDR_W-1:2];

   for (genvar g = 0; g < NUM_WORDS; g++) begin : g_dec
      assign sel[g] = aligned && (word == WORD_W'(g));
   end
   assign wr_sel = {NUM_WORDS{bus_wr}} & sel;
   assign rd_sel = {NUM_WORDS{bus_rd}} & sel;

   logic [REG_W-1:0] ctl_a, ctl_b, ctl_c, guard_q, tmo_q, misc_q, clr_mask, status;
   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_a   <= '0;
         ctl_b   <= '0;
         ctl_c   <= '0;
         div_q   <= '0;
         guard_q <= '0;
         tmo_q   <= '0;
      end else begin
         if (wr_sel[W_CTLA])  ctl_a   <= bus_wdata;
         if (wr_sel[W_CTLB])  ctl_b   <= bus_wdata;
         if (wr_sel[W_CTLC])  ctl_c   <= bus_wdata;
         if (wr_sel[W_DIV])   div_q   <= bus_wdata[DIV_W-1:0];
         if (wr_sel[W_GUARD]) guard_q <= bus_wdata;
         if (wr_sel[W_TMO])   tmo_q   <= bus_wdata;
      end
   end

   assign clr_mask = wr_sel[W_CLR] ? bus_wdata : '0;

   // line-event flags and the constant reset bits
   always_ff @(posedge clk) begin
      if (!rst_n) misc_q <= ST_RESET & ~OWNED_MASK;
      else        misc_q <= ((misc_q & ~clr_mask) | (core_evt & EVT_MASK)) & ~OWNED_MASK;
   end

   logic              rd_rxd, flush_req, rx_full, rx_ovr, tx_empty, tx_done;
   logic              accept_en, ovr_detect, tx_on;
   logic [DATA_W-1:0] rxd_q;

   assign rd_rxd     = rd_sel[W_RXD];
   assign flush_req  = wr_sel[W_REQ] && bus_wdata[RQ_FLUSH];
   assign accept_en  = ctl_a[CA_ON] && ctl_a[CA_RX_ON];
   assign ovr_detect = !ctl_c[CC_OVR_OFF];
   assign tx_on      = ctl_a[CA_TX_ON];

   uart_csr_rx #(.DATA_W(DATA_W)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .accept_en  (accept_en),
      .ovr_detect (ovr_detect),
      .clr_full   (rd_rxd || flush_req || clr_mask[ST_FULL]),
      .clr_ovr    (clr_mask[ST_OVR]),
      .full       (rx_full),
      .ovr        (rx_ovr),
      .rx_ready   (rx_ready),
      .data_q     (rxd_q)
   );

   uart_csr_tx #(.DATA_W(DATA_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wr_sel[W_TXD]),
      .load_data (bus_wdata[DATA_W-1:0]),
      .tx_on     (tx_on),
      .tx_ready  (tx_ready),
      .clr_empty (clr_mask[ST_EMPTY]),
      .clr_done  (clr_mask[ST_DONE]),
      .empty     (tx_empty),
      .done      (tx_done),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data)
   );

   always_comb begin
      status           = misc_q;
      status[ST_OVR]   = rx_ovr;
      status[ST_FULL]  = rx_full;
      status[ST_DONE]  = tx_done;
      status[ST_EMPTY] = tx_empty;
   end

   uart_csr_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .status  (status),
      .enables ({ctl_c, ctl_b, ctl_a}),
      .irq     (irq)
   );

   always_comb begin
      bus_rdata = '0;
      if (rd_sel[W_CTLA])  bus_rdata = ctl_a;
      if (rd_sel[W_CTLB])  bus_rdata = ctl_b;
      if (rd_sel[W_CTLC])  bus_rdata = ctl_c;
      if (rd_sel[W_DIV])   bus_rdata = REG_W'(div_q);
      if (rd_sel[W_GUARD]) bus_rdata = guard_q;
      if (rd_sel[W_TMO])   bus_rdata = tmo_q;
      if (rd_sel[W_STAT])  bus_rdata = status;
      if (rd_sel[W_RXD])   bus_rdata = REG_W'(rxd_q);
      if (rd_sel[W_TXD])   bus_rdata = REG_W'(tx_data);
   end
endmodule

// File: rtl/uart_csr_ctrl_chk.sv
module uart_csr_ctrl_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rx_valid,
   input logic [DATA_W-1:0] rx_data,
   input logic              accept_en,
   input logic              ovr_detect,
   input logic              rx_full,
   input logic              rx_ovr,
   input logic [DATA_W-1:0] rxd_q,
   input logic              rd_rxd,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic              tx_on,
   input logic              tx_empty,
   input logic              tx_done,
   input logic              tdr_load,
   input logic [95:0]       enables,
   input logic              irq
);
   // R3
   rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !accept_en |=> $stable(rxd_q));

   // R4
   rx_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && accept_en && !rx_full |=> rx_full && (rxd_q == $past(rx_data)));

   // R5
   ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && accept_en && rx_full && ovr_detect |=> rx_ovr && $stable(rxd_q));

   // R6
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_rxd && !rx_valid |=> !rx_full);

   // R7
   tx_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> tx_on && !tx_empty);

   // R8
   tx_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready && !tdr_load |=> tx_empty && tx_done);

   // R11
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enables == '0) && ($past(enables) == '0) |-> !irq);
endmodule

bind uart_csr_ctrl uart_csr_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_valid   (rx_valid),
   .rx_data    (rx_data),
   .accept_en  (accept_en),
   .ovr_detect (ovr_detect),
   .rx_full    (rx_full),
   .rx_ovr     (rx_ovr),
   .rxd_q      (rxd_q),
   .rd_rxd     (rd_rxd),
   .tx_valid   (tx_valid),
   .tx_ready   (tx_ready),
   .tx_on      (tx_on),
   .tx_empty   (tx_empty),
   .tx_done    (tx_done),
   .tdr_load   (wr_sel[10]),
   .enables    ({ctl_c, ctl_b, ctl_a}),
   .irq        (irq)
);

// File: tb/uart_csr_ctrl_tb.sv
`timescale 1ns/100ps
module uart_csr_ctrl_tb;
   localparam int DW = 9;
   localparam int AW = 10;
   localparam logic [31:0] EVM = 32'h0012_1B17;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0, bus_rdata;
   logic          rx_valid = 1'b0, rx_ready;
   logic [DW-1:0] rx_data = '0, tx_data;
   logic          tx_valid, tx_ready = 1'b0, irq;
   logic [31:0]   core_evt = '0;

   always #2.5 clk = ~clk;

   uart_csr_ctrl #(.DATA_W(DW), .ADDR_W(AW), .IRQ_REG(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
      .core_evt(core_evt), .irq(irq));

   // reference model state
   logic [31:0]   m_a, m_b, m_c, m_div, m_guard, m_tmo, m_st;
   logic [DW-1:0] m_rxd, m_txd;
   int            errs = 0, checks = 0, cyc = 0;
   string         rd_tag = "R2";

   task automatic model_reset();
      m_a = 0; m_b = 0; m_c = 0; m_div = 0; m_guard = 0; m_tmo = 0;
      m_st = 32'h0200_00C0; m_rxd = '0; m_txd = '0;
   endtask

   function automatic logic model_irq();
      return (m_st[7] & m_a[7]) | (m_st[6] & m_a[6]) | (m_st[5] & m_a[5]) |
             (m_st[4] & m_a[4]) | (m_st[0] & m_a[8]) | (m_st[17] & m_a[14]) |
             (m_st[11] & m_a[26]) | (m_st[12] & m_a[27]) | (m_st[9] & m_c[10]) |
             (m_st[8] & m_b[6]) | (m_st[20] & m_c[22]) | (m_st[1] & m_c[0]) |
             (m_st[3] & (m_a[5] | m_c[0]));
   endfunction

   function automatic logic [31:0] model_rd(logic [AW-1:0] a);
      if (a[1:0] != 2'b00) return 32'h0;
      case (int'(a >> 2))
         0: return m_a;
         1: return m_b;
         2: return m_c;
         3: return m_div & 32'h0000_FFFF;
         4: return m_guard;
         5: return m_tmo;
         7: return m_st;
         9: return 32'(m_rxd);
         10: return 32'(m_txd);
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic hit(int idx);
      return (bus_addr[1:0] == 2'b00) && (int'(bus_addr >> 2) == idx);
   endfunction

   task automatic model_step();
      logic [31:0] icr, n;
      logic rx_on, store, lost, done, load;
      icr   = (bus_wr && hit(8)) ? bus_wdata : 32'h0;
      rx_on = m_a[0] & m_a[2];
      store = rx_valid && rx_on && (!m_st[5] || m_c[12]);
      lost  = rx_valid && rx_on && m_st[5] && !m_c[12];
      done  = !m_st[7] && m_a[3] && tx_ready;
      load  = bus_wr && hit(10);
      n = (m_st & ~icr) | (core_evt & EVM);
      if (store) n[5] = 1'b1;
      else if ((bus_rd && hit(9)) || (bus_wr && hit(6) && bus_wdata[3])) n[5] = 1'b0;
      if (lost) n[3] = 1'b1;
      if (done) n[6] = 1'b1;
      if (load) n[7] = 1'b0;
      else if (done) n[7] = 1'b1;
      m_st = n;
      if (store) m_rxd = rx_data;
      if (load) m_txd = bus_wdata[DW-1:0];
      if (bus_wr && hit(0)) m_a = bus_wdata;
      if (bus_wr && hit(1)) m_b = bus_wdata;
      if (bus_wr && hit(2)) m_c = bus_wdata;
      if (bus_wr && hit(3)) m_div = bus_wdata;
      if (bus_wr && hit(4)) m_guard = bus_wdata;
      if (bus_wr && hit(5)) m_tmo = bus_wdata;
   endtask

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s act=%h exp=%h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   // one clock: compare before the edge, advance the model at the edge
   task automatic cycle();
      #1;
      chk("R4 rx_ready", 32'(rx_ready), 32'(!m_st[5]));
      chk("R7 tx_valid", 32'(tx_valid), 32'(!m_st[7] && m_a[3]));
      if (!m_st[7] && m_a[3]) chk("R7 tx_data", 32'(tx_data), 32'(m_txd));
      chk("R11 R12 irq", 32'(irq), 32'(model_irq()));
      if (bus_rd) chk(rd_tag, bus_rdata, model_rd(bus_addr));
      @(posedge clk);
      model_step();
      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0; rx_valid = 1'b0; core_evt = '0;
   endtask

   task automatic wr(int a, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
      cycle();
   endtask

   task automatic rd(int a, string tag);
      bus_rd = 1'b1; bus_addr = AW'(a); rd_tag = tag;
      cycle();
   endtask

   task automatic rxb(logic [DW-1:0] d);
      rx_valid = 1'b1; rx_data = d;
      cycle();
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errs++; checks++;
         $display("FAIL watchdog act=%0d exp<=100000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state across the whole map
      for (int a = 0; a <= 40; a += 4) rd(a, "R1 reset read");

      // R2 storage, divisor width, write-only words, bad addresses
      wr(4, 32'hA5A5_5A5A); wr(8, 32'h0000_0F00); wr(12, 32'hFFFF_FFFF);
      wr(16, 32'h1234_5678); wr(20, 32'h8765_4321);
      for (int a = 4; a <= 20; a += 4) rd(a, "R2 readback");
      wr(24, 32'h0000_0000); rd(24, "R2 request reads zero");
      rd(32, "R2 clear reads zero");
      wr(1, 32'hFFFF_FFFF); rd(0, "R2 unaligned write ignored");
      wr(44, 32'hFFFF_FFFF); wr(1020, 32'hFFFF_FFFF);
      rd(44, "R2 unmapped read"); rd(1020, "R2 far unmapped read"); rd(6, "R2 unaligned read");
      wr(8, 32'h0); wr(4, 32'h0);

      // R9 writes to status and receive data ignored
      wr(28, 32'h0000_0000); wr(36, 32'h0000_01FF);
      rd(28, "R9 status write ignored"); rd(36, "R9 rxd write ignored");

      // R3 receiver off
      rxb(9'h1A5); rd(36, "R3 dropped while off");
      wr(0, 32'h1); rxb(9'h0F0); rd(28, "R3 dropped enable only");
      wr(0, 32'h4); rxb(9'h0F1); rd(36, "R3 dropped rx-on only");

      // R4 / R6 store and read
      wr(0, 32'h5); rxb(9'h155);
      rd(28, "R4 full flag set"); rd(36, "R6 read data");
      rd(28, "R6 read clears full");
      rxb(9'h1FF); rd(36, "R4 top bit of field");

      // R5 overrun keeps old character
      rxb(9'h011); rxb(9'h022);
      rd(28, "R5 overrun flag"); rd(36, "R5 old kept");
      wr(32, 32'h8); rd(28, "R9 overrun cleared");
      wr(8, 32'h1000); rxb(9'h033); rxb(9'h044);
      rd(28, "R5 no overrun when off"); rd(36, "R5 overwritten");
      wr(8, 32'h0);

      // R6 flush, and store wins over read in one cycle
      rxb(9'h055); wr(24, 32'h8); rd(28, "R6 flush clears full");
      rxb(9'h066);
      wr(8, 32'h1000);
      bus_rd = 1'b1; bus_addr = AW'(36); rd_tag = "R6 read with store"; rx_valid = 1'b1; rx_data = 9'h077; cycle();
      rd(28, "R6 store wins"); rd(36, "R6 new data");
      wr(8, 32'h0);

      // R7 / R8 transmit
      tx_ready = 1'b0; wr(40, 32'h1C3);
      rd(28, "R7 empty cleared"); rd(40, "R7 data stored");
      wr(0, 32'hD); cycle(); cycle();
      rd(28, "R8 held while not ready");
      tx_ready = 1'b1; cycle(); rd(28, "R8 taken sets empty and done");
      wr(32, 32'h40); rd(28, "R9 done cleared");
      wr(40, 32'h0AA); wr(40, 32'h0BB); rd(28, "R8 load wins in taking cycle");
      cycle(); rd(28, "R8 second taken");
      tx_ready = 1'b0;

      // R10 line events and set-over-clear
      core_evt = 32'hFFFF_FFFF; cycle(); rd(28, "R10 only event positions");
      wr(32, 32'hFFFF_FFFF); rd(28, "R9 clear all");
      core_evt = 32'h0000_0010; wr(32, 32'h0000_0010); rd(28, "R9 set wins over clear");

      // R11 / R12 walk each enable with every flag up
      wr(0, 32'h0); wr(8, 32'h1000); rxb(9'h101); wr(8, 32'h0);
      wr(0, 32'h5); rxb(9'h102); rxb(9'h103); wr(0, 32'h0);
      core_evt = 32'hFFFF_FFFF; cycle();
      foreach (m_st[i]) begin
         wr(0, 32'h1 << i); rd(28, "R11 flag view");
         wr(0, 32'h0);
         wr(4, 32'h1 << i); wr(4, 32'h0);
         wr(8, 32'h1 << i); wr(8, 32'h0);
      end
      wr(0, 32'h0C00_41F0); wr(4, 32'h40); wr(8, 32'h0040_0401);
      for (int b = 0; b < 32; b++) wr(32, 32'h1 << b);
      rd(28, "R12 all cleared");
      wr(8, 32'h0); wr(32, 32'h0); cycle();
      chk("R12 irq low", 32'(irq), 32'h0);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule